// File: doc/BRIEF.md
# Interrupt and Event Wake Controller

This controller sits next to a single in-order processor core. It watches up to 32 interrupt lines and a smaller group of event lines. A rising edge on any line sets that line's pending bit. Among the interrupts that are both pending and enabled, the controller picks one and offers the core a handler address computed from a programmable base. When the core has served the interrupt, it names the line back with an acknowledge pulse, and that pending bit clears.

The controller also owns the core's clock enable. When the core has nothing to do, it raises a sleep request. The controller then drops the registered clock enable. It raises the enable again once an enabled event or enabled interrupt becomes pending. Software sets the enable masks and the vector base, reads the pending bits and clears them, all through an APB slave port. That port has no wait states and decodes its word registers from address bits [4:2].

Top module: `irq_wake_ctrl`

## Requirements
- R1: After reset, both enable masks and both pending registers read 0, the vector base reads 0x0000_0100, `core_clk_en` is 1 and `irq_valid` is 0.
- R2: The registers sit at these byte offsets: interrupt enable 0x00, event enable 0x04, interrupt pending 0x08, event pending 0x0C, vector base 0x10. The enables and the base can be read back. Writes to the base force bits [1:0] to 0.
- R3: A 0-to-1 transition on an interrupt or event line, sampled at a clock edge, sets the line's pending bit at that same edge. A line that is held high does not set the bit again after the bit has been cleared.
- R4: Writing to a pending register clears each bit written as 1. Bits written as 0 keep their value.
- R5: If a new rising edge on a line lands in the same cycle as a clear of that line's pending bit (by write or by acknowledge), the bit stays set.
- R6: `irq_valid` is high exactly when some interrupt is both pending and enabled. `irq_id` is then the lowest-numbered such line. A masked line is never selected.
- R7: `irq_vector` equals the vector base plus 4 times `irq_id`.
- R8: When `irq_ack` is high at a clock edge, the pending bit of line `irq_ack_id` is cleared at that edge (subject to R5).
- R9: If `sleep_req` is high at a clock edge while no enabled interrupt or event is pending, `core_clk_en` is 0 from that edge on. `core_clk_en` falls only after such a request.
- R10: If any enabled interrupt or event is already pending, a sleep request is ignored and `core_clk_en` stays 1.
- R11: While asleep, `core_clk_en` rises at the first edge after an enabled pending bit is set. That is two edges after a line's rising edge is first presented. A pending line whose enable is 0 does not wake the core.
- R12: `pready` is always 1. Reads of offsets 0x14 to 0x1C, and reads with any address bit above bit 4 set, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, never gated |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| irq_lines | input | NUM_IRQ | Interrupt request lines |
| evt_lines | input | NUM_EVT | Event lines |
| irq_ack | input | 1 | Core acknowledges a served interrupt |
| irq_ack_id | input | ID_W | Index of the acknowledged line |
| sleep_req | input | 1 | Core asks to sleep until woken |
| irq_valid | output | 1 | An enabled interrupt is pending |
| irq_id | output | ID_W | Index of the selected interrupt |
| irq_vector | output | 32 | Handler address for the selected interrupt |
| core_clk_en | output | 1 | Registered clock enable for the core |

## Verification
Two pairs of actions can land in the same clock cycle. The first pair is a pending bit being cleared while the same line makes a fresh rising edge. The bench provokes this by driving an acknowledge for a line in the same cycle as it re-raises that line, then reads the pending register back through APB to confirm the bit survived. The second pair is a sleep request arriving while a wake source is already pending. The bench leaves an enabled event pending, raises the sleep request, and checks that the clock enable never drops.

// File: rtl/iwc_pkg.sv
package iwc_pkg;

    typedef enum logic [2:0] {
        RG_IRQ_EN   = 3'd0,
        RG_EVT_EN   = 3'd1,
        RG_IRQ_PEND = 3'd2,
        RG_EVT_PEND = 3'd3,
        RG_VBASE    = 3'd4
    } reg_idx_e;

    typedef enum logic {
        ST_RUN,
        ST_NAP
    } nap_state_e;

    typedef struct packed {
        logic        hit;
        logic        wr;
        reg_idx_e    idx;
        logic [31:0] data;
    } bus_op_t;

    function automatic logic [31:0] vec_addr(input logic [31:0] base, input logic [31:0] idx);
        return base + (idx << 2);
    endfunction

endpackage

// File: rtl/iwc_edge_det.sv
module iwc_edge_det #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lines,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lines;
    end

    assign rise = lines & ~prev_q;
endmodule

// File: rtl/iwc_regs.sv
module iwc_regs
    import iwc_pkg::*;
#(
    parameter int          NUM_IRQ   = 32,
    parameter int          NUM_EVT   = 8,
    parameter int          ADDR_W    = 12,
    parameter logic [31:0] VBASE_RST = 32'h0000_0100,
    localparam int         ID_W      = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [31:0]        pwdata,
    output logic [31:0]        prdata,
    input  logic [NUM_IRQ-1:0] irq_rise,
    input  logic [NUM_EVT-1:0] evt_rise,
    input  logic               irq_ack,
    input  logic [ID_W-1:0]    irq_ack_id,
    output logic [NUM_IRQ-1:0] irq_en,
    output logic [NUM_EVT-1:0] evt_en,
    output logic [NUM_IRQ-1:0] irq_pend,
    output logic [NUM_EVT-1:0] evt_pend,
    output logic [31:0]        vbase
);
    bus_op_t            op;
    logic [NUM_IRQ-1:0] irq_w1c;
    logic [NUM_IRQ-1:0] irq_ackm;
    logic [NUM_EVT-1:0] evt_w1c;

    always_comb begin
        op.hit  = psel && (paddr[ADDR_W-1:5] == '0);
        op.wr   = op.hit && penable && pwrite;
        op.idx  = reg_idx_e'(paddr[4:2]);
        op.data = pwdata;
    end

    always_comb begin
        irq_w1c = (op.wr && op.idx == RG_IRQ_PEND) ? op.data[NUM_IRQ-1:0] : '0;
        evt_w1c = (op.wr && op.idx == RG_EVT_PEND) ? op.data[NUM_EVT-1:0] : '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            irq_ackm[i] = irq_ack && (irq_ack_id == ID_W'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_en   <= '0;
            evt_en   <= '0;
            irq_pend <= '0;
            evt_pend <= '0;
            vbase    <= VBASE_RST;
        end else begin
            if (op.wr && op.idx == RG_IRQ_EN) irq_en <= op.data[NUM_IRQ-1:0];
            if (op.wr && op.idx == RG_EVT_EN) evt_en <= op.data[NUM_EVT-1:0];
            if (op.wr && op.idx == RG_VBASE)  vbase  <= {op.data[31:2], 2'b00};
            // a fresh edge outranks any clear arriving in the same cycle
            irq_pend <= (irq_pend & ~irq_w1c & ~irq_ackm) | irq_rise;
            evt_pend <= (evt_pend & ~evt_w1c) | evt_rise;
        end
    end

    always_comb begin
        prdata = '0;
        if (op.hit) begin
            case (op.idx)
                RG_IRQ_EN:   prdata = 32'(irq_en);
                RG_EVT_EN:   prdata = 32'(evt_en);
                RG_IRQ_PEND: prdata = 32'(irq_pend);
                RG_EVT_PEND: prdata = 32'(evt_pend);
                RG_VBASE:    prdata = vbase;
                default:     prdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/iwc_prio_sel.sv
module iwc_prio_sel
    import iwc_pkg::*;
#(
    parameter int  NUM_IRQ = 32,
    localparam int ID_W    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic [NUM_IRQ-1:0] req,
    input  logic [31:0]        base,
    output logic               valid,
    output logic [ID_W-1:0]    id,
    output logic [31:0]        vector
);
    always_comb begin
        valid = 1'b0;
        id    = '0;
        // scan downward so the lowest index is assigned last and wins
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                id    = ID_W'(i);
            end
        end
        vector = vec_addr(base, 32'(id));
    end
endmodule

// File: rtl/iwc_nap_ctrl.sv
module iwc_nap_ctrl
    import iwc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sleep_req,
    input  logic wake_any,
    output logic clk_en
);
    nap_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            clk_en  <= 1'b1;
        end else begin
            case (state_q)
                ST_RUN: if (sleep_req && !wake_any) begin
                    state_q <= ST_NAP;
                    clk_en  <= 1'b0;
                end
                ST_NAP: if (wake_any) begin
                    state_q <= ST_RUN;
                    clk_en  <= 1'b1;
                end
                default: begin
                    state_q <= ST_RUN;
                    clk_en  <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
    import iwc_pkg::*;
#(
    parameter int          NUM_IRQ   = 32,
    parameter int          NUM_EVT   = 8,
    parameter int          ADDR_W    = 12,
    parameter logic [31:0] VBASE_RST = 32'h0000_0100,
    localparam int         ID_W      = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [31:0]        pwdata,
    output logic [31:0]        prdata,
    output logic               pready,
    input  logic [NUM_IRQ-1:0] irq_lines,
    input  logic [NUM_EVT-1:0] evt_lines,
    input  logic               irq_ack,
    input  logic [ID_W-1:0]    irq_ack_id,
    input  logic               sleep_req,
    output logic               irq_valid,
    output logic [ID_W-1:0]    irq_id,
    output logic [31:0]        irq_vector,
    output logic               core_clk_en
);
    logic [NUM_IRQ-1:0] irq_rise, irq_en, irq_pend;
    logic [NUM_EVT-1:0] evt_rise, evt_en, evt_pend;
    logic [31:0]        vbase;
    logic               wake_any;

    assign pready = 1'b1;

    iwc_edge_det #(.W(NUM_IRQ)) irq_edge_i (
        .clk(clk), .rst(rst), .lines(irq_lines), .rise(irq_rise)
    );

    iwc_edge_det #(.W(NUM_EVT)) evt_edge_i (
        .clk(clk), .rst(rst), .lines(evt_lines), .rise(evt_rise)
    );

    iwc_regs #(
        .NUM_IRQ(NUM_IRQ), .NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W), .VBASE_RST(VBASE_RST)
    ) regs_i (
        .clk(clk), .rst(rst),
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .pwdata(pwdata), .prdata(prdata),
        .irq_rise(irq_rise), .evt_rise(evt_rise),
        .irq_ack(irq_ack), .irq_ack_id(irq_ack_id),
        .irq_en(irq_en), .evt_en(evt_en),
        .irq_pend(irq_pend), .evt_pend(evt_pend), .vbase(vbase)
    );

    iwc_prio_sel #(.NUM_IRQ(NUM_IRQ)) sel_i (
        .req(irq_pend & irq_en), .base(vbase),
        .valid(irq_valid), .id(irq_id), .vector(irq_vector)
    );

    assign wake_any = (|(irq_pend & irq_en)) || (|(evt_pend & evt_en));

    iwc_nap_ctrl nap_i (
        .clk(clk), .rst(rst), .sleep_req(sleep_req),
        .wake_any(wake_any), .clk_en(core_clk_en)
    );
endmodule

// File: rtl/iwc_checker.sv
module iwc_checker #(
    parameter int  NUM_IRQ = 32,
    parameter int  NUM_EVT = 8,
    parameter int  ADDR_W  = 12,
    localparam int ID_W    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input logic               clk,
    input logic               rst,
    input logic               psel,
    input logic [ADDR_W-1:0]  paddr,
    input logic [31:0]        prdata,
    input logic [NUM_IRQ-1:0] irq_rise,
    input logic [NUM_IRQ-1:0] irq_en,
    input logic [NUM_IRQ-1:0] irq_pend,
    input logic [NUM_EVT-1:0] evt_en,
    input logic [NUM_EVT-1:0] evt_pend,
    input logic [31:0]        vbase,
    input logic               irq_ack,
    input logic [ID_W-1:0]    irq_ack_id,
    input logic               sleep_req,
    input logic               irq_valid,
    input logic [ID_W-1:0]    irq_id,
    input logic [31:0]        irq_vector,
    input logic               core_clk_en
);
    logic wake_seen;
    assign wake_seen = (|(irq_pend & irq_en)) || (|(evt_pend & evt_en));

    p_sel_pending_r6: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (irq_pend[irq_id] && irq_en[irq_id]));

    p_vector_r7: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (irq_vector == vbase + {{(30-ID_W){1'b0}}, irq_id, 2'b00}));

    p_ack_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !irq_rise[irq_ack_id]) |=> !irq_pend[$past(irq_ack_id)]);

    p_fall_needs_req_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(core_clk_en) |-> $past(sleep_req));

    p_no_nap_when_pending_r10: assert property (@(posedge clk) disable iff (rst)
        (core_clk_en && sleep_req && wake_seen) |=> core_clk_en);

    p_wake_next_r11: assert property (@(posedge clk) disable iff (rst)
        (!core_clk_en && wake_seen) |=> core_clk_en);

    p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (rst)
        (psel && (paddr[4:2] > 3'd4)) |-> (prdata == 32'd0));
endmodule

bind irq_wake_ctrl iwc_checker #(
    .NUM_IRQ(NUM_IRQ), .NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W)
) chk_i (
    .clk(clk), .rst(rst), .psel(psel), .paddr(paddr), .prdata(prdata),
    .irq_rise(irq_rise), .irq_en(irq_en), .irq_pend(irq_pend),
    .evt_en(evt_en), .evt_pend(evt_pend), .vbase(vbase),
    .irq_ack(irq_ack), .irq_ack_id(irq_ack_id), .sleep_req(sleep_req),
    .irq_valid(irq_valid), .irq_id(irq_id), .irq_vector(irq_vector),
    .core_clk_en(core_clk_en)
);

// File: tb/irq_wake_ctrl_tb_top.sv
module irq_wake_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NI = 32;
    localparam int NE = 8;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic          psel, penable, pwrite;
    logic [AW-1:0] paddr;
    logic [31:0]   pwdata, prdata;
    logic          pready;
    logic [NI-1:0] irq_lines;
    logic [NE-1:0] evt_lines;
    logic          irq_ack;
    logic [4:0]    irq_ack_id;
    logic          sleep_req;
    logic          irq_valid;
    logic [4:0]    irq_id;
    logic [31:0]   irq_vector;
    logic          core_clk_en;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_wake_ctrl #(.NUM_IRQ(NI), .NUM_EVT(NE), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .irq_lines(irq_lines), .evt_lines(evt_lines), .irq_ack(irq_ack),
        .irq_ack_id(irq_ack_id), .sleep_req(sleep_req), .irq_valid(irq_valid),
        .irq_id(irq_id), .irq_vector(irq_vector), .core_clk_en(core_clk_en)
    );

    // priority table: enable mask, line pattern, expected valid, expected id
    localparam int NV = 6;
    localparam logic [31:0] T_EN   [NV] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFEF,
                                            32'h0000_0000, 32'h0000_0C00, 32'hFFFF_FFFF};
    localparam logic [31:0] T_LN   [NV] = '{32'h0000_0001, 32'h8000_0010, 32'h8000_0010,
                                            32'h0000_0F00, 32'h0000_0F00, 32'h8000_0000};
    localparam logic        T_VAL  [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
    localparam int          T_ID   [NV] = '{0, 4, 31, 0, 10, 31};

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic apb_wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        rst = 1'b1; psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
        irq_lines = '0; evt_lines = '0; irq_ack = 0; irq_ack_id = '0; sleep_req = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 clk_en", 32'(core_clk_en), 32'd1);
        check("R1 irq_valid", 32'(irq_valid), 32'd0);
        check("R12 pready", 32'(pready), 32'd1);
        apb_rd(12'h000, rd); check("R1 irq_en", rd, 32'h0);
        apb_rd(12'h004, rd); check("R1 evt_en", rd, 32'h0);
        apb_rd(12'h008, rd); check("R1 irq_pend", rd, 32'h0);
        apb_rd(12'h00C, rd); check("R1 evt_pend", rd, 32'h0);
        apb_rd(12'h010, rd); check("R1 vbase", rd, 32'h0000_0100);

        // R6 R7 table walk
        for (int k = 0; k < NV; k++) begin
            apb_wr(12'h000, T_EN[k]);
            @(negedge clk); irq_lines = T_LN[k];
            @(negedge clk);
            check("R6 valid", 32'(irq_valid), 32'(T_VAL[k]));
            if (T_VAL[k]) begin
                check("R6 id", 32'(irq_id), T_ID[k]);
                check("R7 vector", irq_vector, 32'h100 + 32'(T_ID[k]) * 4);
            end
            apb_wr(12'h008, 32'hFFFF_FFFF);
            apb_rd(12'h008, rd);
            check("R3 R4 held lines no reset", rd, 32'h0);
            irq_lines = '0;
        end

        // R2 enable and base readback
        apb_wr(12'h004, 32'h0000_00A5);
        apb_rd(12'h004, rd); check("R2 evt_en", rd, 32'h0000_00A5);
        apb_wr(12'h010, 32'h2000_0003);
        apb_rd(12'h010, rd); check("R2 vbase", rd, 32'h2000_0000);
        apb_wr(12'h000, 32'hFFFF_FFFF);
        @(negedge clk); irq_lines[5] = 1'b1;
        @(negedge clk);
        check("R7 vector new base", irq_vector, 32'h2000_0014);

        // R4 writing zero leaves it pending
        apb_wr(12'h008, 32'h0000_0000);
        apb_rd(12'h008, rd); check("R4 zero write", rd, 32'h0000_0020);

        // R8 acknowledge clears
        @(negedge clk); irq_ack = 1'b1; irq_ack_id = 5'd5;
        @(negedge clk); irq_ack = 1'b0;
        check("R8 valid after ack", 32'(irq_valid), 32'd0);
        apb_rd(12'h008, rd); check("R8 pend after ack", rd, 32'h0);
        irq_lines = '0;

        // R5 ack and fresh edge in the same cycle
        @(negedge clk); irq_lines[7] = 1'b1;
        @(negedge clk); irq_lines[7] = 1'b0;
        @(negedge clk); irq_lines[7] = 1'b1; irq_ack = 1'b1; irq_ack_id = 5'd7;
        @(negedge clk); irq_ack = 1'b0;
        apb_rd(12'h008, rd); check("R5 edge beats ack", rd, 32'h0000_0080);
        apb_wr(12'h008, 32'h0000_0080);
        irq_lines = '0;

        // R12 unmapped reads
        apb_rd(12'h01C, rd); check("R12 unmapped", rd, 32'h0);
        apb_rd(12'h020, rd); check("R12 high addr", rd, 32'h0);

        // R9 sleep with nothing pending
        apb_wr(12'h000, 32'h0000_0004);
        apb_wr(12'h004, 32'h0000_0001);
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
        check("R9 asleep", 32'(core_clk_en), 32'd0);

        // R11 masked event does not wake
        evt_lines[1] = 1'b1;
        repeat (3) @(negedge clk);
        check("R11 masked stays asleep", 32'(core_clk_en), 32'd0);
        evt_lines[0] = 1'b1;
        @(negedge clk);
        check("R11 not yet awake", 32'(core_clk_en), 32'd0);
        @(negedge clk);
        check("R11 awake", 32'(core_clk_en), 32'd1);

        // R10 sleep ignored while enabled event pending
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
        check("R10 ignored", 32'(core_clk_en), 32'd1);
        @(negedge clk);
        check("R10 still awake", 32'(core_clk_en), 32'd1);

        // R9 R11 clear, sleep again, wake by interrupt line 2
        apb_wr(12'h00C, 32'h0000_00FF);
        apb_rd(12'h00C, rd); check("R4 evt cleared", rd, 32'h0);
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
        check("R9 asleep again", 32'(core_clk_en), 32'd0);
        irq_lines[2] = 1'b1;
        @(negedge clk);
        check("R11 irq not yet awake", 32'(core_clk_en), 32'd0);
        @(negedge clk);
        check("R11 irq awake", 32'(core_clk_en), 32'd1);
        check("R7 wake vector", irq_vector, 32'h2000_0008);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule